// File: doc/BRIEF.md
# Exception Entry and Priority Controller

This block decides which pending exception a 32-bit core takes. It then produces the state update for entering that exception. Seven request sources arrive as levels. The block masks the two interrupt lines with the disable bits of the current status word. At an instruction boundary it picks the highest-priority source that remains. One cycle later it presents the following on a one-cycle strobe:

- the target mode,
- the vector address,
- the value for the target mode's link register,
- the old status word to be saved,
- the new current status word.

A reset request does not wait for a boundary.

The block keeps one saved status copy for each exception mode. When the core requests an exception return, the block looks up the copy that belongs to the mode in the current status word. It hands that copy back together with the resume address, so both can be applied in a single step.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Among the requests that are active and allowed, the winner is chosen in this order, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. Undefined instruction wins the tie with software interrupt.
- R2: The vector output for each winner is: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R3: The mode output, which also appears in new status bits 4:0, is set by the winner:
  - reset and software interrupt give 10011;
  - either abort gives 10111;
  - undefined gives 11011;
  - fast interrupt gives 10001;
  - normal interrupt gives 10010.
- R4: On entry, the saved-status output equals the status input sampled in the accepting cycle. The link output equals the return-address input sampled in the same cycle.
- R5: The new status word is the old one with these changes:
  - bits 4:0 are replaced by the mode;
  - bit 5 is cleared;
  - bit 7 is set;
  - bit 6 is set only when the winner is a fast interrupt or a reset, and is otherwise kept.
- R6: A normal interrupt request is ignored while status bit 7 is 1. A fast interrupt request is ignored while status bit 6 is 1.
- R7: All sources other than reset are considered only in a cycle where the boundary input is high. A reset request is accepted in any cycle.
- R8: The entry strobe is high for exactly the cycle after an accepting cycle. While nothing is accepted, the entry data outputs keep their values.
- R9: A return request in an exception mode raises the return strobe in the next cycle. The restored status output carries the copy saved on the last entry into that mode, and the PC output carries the resume address.
- R10: A return request has no effect in either of two cases: the current mode is user (10000) or system (11111), or an entry is accepted in the same cycle. The two strobes are never high together.
- R11: With the synchronous reset high, both strobes are low at the next edge, and all outputs and saved copies are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| reset_req | input | 1 | Reset exception request |
| dabort_req | input | 1 | Data abort request |
| fiq_req | input | 1 | Fast interrupt level |
| irq_req | input | 1 | Normal interrupt level |
| pabort_req | input | 1 | Prefetch abort request |
| undef_req | input | 1 | Undefined instruction request |
| swi_req | input | 1 | Software interrupt request |
| boundary | input | 1 | Instruction boundary reached |
| ret_req | input | 1 | Exception return request |
| cur_psr | input | 32 | Current status word |
| ret_addr | input | 32 | Return address to save on entry |
| resume_pc | input | 32 | PC to reload on return |
| take_valid | output | 1 | Entry strobe |
| take_mode | output | 5 | Target mode |
| take_vector | output | 32 | Vector address |
| take_link | output | 32 | Link register value |
| take_spsr | output | 32 | Status word to save |
| take_psr | output | 32 | New current status word |
| ret_valid | output | 1 | Return strobe |
| ret_psr | output | 32 | Restored status word |
| ret_pc | output | 32 | PC to reload |

## Verification
The bench sweeps every combination of the seven requests against both mask bits and the boundary input. This catches a design that inverts two priority levels, which would vector to the wrong address. It also catches one that lets a masked interrupt through, or that takes a synchronous fault off a boundary. After each accept the bench checks that an idle cycle leaves the entry outputs untouched, so a design that clears or re-latches them on idle would be caught. Return tests enter two different interrupt modes and then return from the first one. A shared or misindexed saved copy would hand back the wrong status word. Other return tests issue a return in user mode, and a return in the same cycle as an entry, where a design that ignored the conflict would raise both strobes.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN    = 32;
    localparam int NUM_SRC = 7;
    localparam int MODE_W  = 5;
    localparam int NBANK   = 5;
    localparam int BANK_W  = $clog2(NBANK);

    // status word bit positions
    localparam int PSR_T = 5;
    localparam int PSR_F = 6;
    localparam int PSR_I = 7;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MODE_USR = 5'b10000;
    localparam mode_t MODE_FIQ = 5'b10001;
    localparam mode_t MODE_IRQ = 5'b10010;
    localparam mode_t MODE_SVC = 5'b10011;
    localparam mode_t MODE_ABT = 5'b10111;
    localparam mode_t MODE_UND = 5'b11011;
    localparam mode_t MODE_SYS = 5'b11111;

    // index order is priority order, lowest index wins
    typedef enum logic [2:0] {
        SRC_RESET = 3'd0,
        SRC_DABT  = 3'd1,
        SRC_FIQ   = 3'd2,
        SRC_IRQ   = 3'd3,
        SRC_PABT  = 3'd4,
        SRC_UNDEF = 3'd5,
        SRC_SWI   = 3'd6
    } src_e;

    typedef struct packed {
        mode_t           mode;
        logic [XLEN-1:0] vector;
        logic [XLEN-1:0] link;
        logic [XLEN-1:0] spsr;
        logic [XLEN-1:0] psr;
    } entry_t;

    function automatic mode_t src_to_mode(src_e s);
        case (s)
            SRC_RESET, SRC_SWI: return MODE_SVC;
            SRC_DABT, SRC_PABT: return MODE_ABT;
            SRC_FIQ:            return MODE_FIQ;
            SRC_IRQ:            return MODE_IRQ;
            default:            return MODE_UND;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] src_to_vector(src_e s);
        case (s)
            SRC_RESET: return XLEN'(32'h00);
            SRC_UNDEF: return XLEN'(32'h04);
            SRC_SWI:   return XLEN'(32'h08);
            SRC_PABT:  return XLEN'(32'h0C);
            SRC_DABT:  return XLEN'(32'h10);
            SRC_IRQ:   return XLEN'(32'h18);
            default:   return XLEN'(32'h1C);
        endcase
    endfunction

    function automatic logic mode_has_bank(mode_t m);
        return (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND) ||
               (m == MODE_IRQ) || (m == MODE_FIQ);
    endfunction

    function automatic logic [BANK_W-1:0] mode_to_bank(mode_t m);
        case (m)
            MODE_ABT: return BANK_W'(1);
            MODE_UND: return BANK_W'(2);
            MODE_IRQ: return BANK_W'(3);
            MODE_FIQ: return BANK_W'(4);
            default:  return BANK_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] req,
    output logic         any,
    output src_e         win
);
    always_comb begin
        any = |req;
        win = SRC_RESET;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) win = src_e'(3'(i));
        end
    end
endmodule

// File: rtl/exc_entry_build.sv
module exc_entry_build
    import exc_pkg::*;
(
    input  src_e            src,
    input  logic [XLEN-1:0] cur_psr,
    input  logic [XLEN-1:0] ret_addr,
    output entry_t          ent
);
    always_comb begin
        ent.mode         = src_to_mode(src);
        ent.vector       = src_to_vector(src);
        ent.link         = ret_addr;
        ent.spsr         = cur_psr;
        ent.psr          = cur_psr;
        ent.psr[MODE_W-1:0] = ent.mode;
        ent.psr[PSR_T]   = 1'b0;
        ent.psr[PSR_I]   = 1'b1;
        if (src == SRC_FIQ || src == SRC_RESET) ent.psr[PSR_F] = 1'b1;
    end
endmodule

// File: rtl/exc_spsr_bank.sv
module exc_spsr_bank
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  mode_t           wr_mode,
    input  logic [XLEN-1:0] wr_data,
    input  mode_t           rd_mode,
    output logic            rd_hit,
    output logic [XLEN-1:0] rd_data
);
    logic [XLEN-1:0] store [NBANK];
    logic [BANK_W-1:0] wr_idx;
    logic [BANK_W-1:0] rd_idx;

    assign wr_idx = mode_to_bank(wr_mode);
    assign rd_idx = mode_to_bank(rd_mode);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                store[b] <= '0;
            end else if (wr_en && mode_has_bank(wr_mode) && wr_idx == BANK_W'(b)) begin
                store[b] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_hit  = mode_has_bank(rd_mode);
        rd_data = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (rd_idx == BANK_W'(b)) rd_data = store[b];
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reset_req,
    input  logic        dabort_req,
    input  logic        fiq_req,
    input  logic        irq_req,
    input  logic        pabort_req,
    input  logic        undef_req,
    input  logic        swi_req,
    input  logic        boundary,
    input  logic        ret_req,
    input  logic [31:0] cur_psr,
    input  logic [31:0] ret_addr,
    input  logic [31:0] resume_pc,
    output logic        take_valid,
    output logic [4:0]  take_mode,
    output logic [31:0] take_vector,
    output logic [31:0] take_link,
    output logic [31:0] take_spsr,
    output logic [31:0] take_psr,
    output logic        ret_valid,
    output logic [31:0] ret_psr,
    output logic [31:0] ret_pc
);
    logic [NUM_SRC-1:0] req_vec;
    logic               accept;
    src_e               winner;
    entry_t             ent;
    logic               bank_hit;
    logic [XLEN-1:0]    bank_psr;
    logic               ret_go;

    // reset bypasses the boundary, interrupts honour their disable bits
    always_comb begin
        req_vec             = '0;
        req_vec[SRC_RESET]  = reset_req;
        req_vec[SRC_DABT]   = boundary & dabort_req;
        req_vec[SRC_FIQ]    = boundary & fiq_req & ~cur_psr[PSR_F];
        req_vec[SRC_IRQ]    = boundary & irq_req & ~cur_psr[PSR_I];
        req_vec[SRC_PABT]   = boundary & pabort_req;
        req_vec[SRC_UNDEF]  = boundary & undef_req;
        req_vec[SRC_SWI]    = boundary & swi_req;
    end

    exc_arbiter #(.N(NUM_SRC)) u_arb (
        .req (req_vec),
        .any (accept),
        .win (winner)
    );

    exc_entry_build u_build (
        .src      (winner),
        .cur_psr  (cur_psr),
        .ret_addr (ret_addr),
        .ent      (ent)
    );

    exc_spsr_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr_mode (ent.mode),
        .wr_data (cur_psr),
        .rd_mode (cur_psr[MODE_W-1:0]),
        .rd_hit  (bank_hit),
        .rd_data (bank_psr)
    );

    assign ret_go = ret_req & ~accept & bank_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_valid  <= 1'b0;
            take_mode   <= '0;
            take_vector <= '0;
            take_link   <= '0;
            take_spsr   <= '0;
            take_psr    <= '0;
            ret_valid   <= 1'b0;
            ret_psr     <= '0;
            ret_pc      <= '0;
        end else begin
            take_valid <= accept;
            ret_valid  <= ret_go;
            if (accept) begin
                take_mode   <= ent.mode;
                take_vector <= ent.vector;
                take_link   <= ent.link;
                take_spsr   <= ent.spsr;
                take_psr    <= ent.psr;
            end
            if (ret_go) begin
                ret_psr <= bank_psr;
                ret_pc  <= resume_pc;
            end
        end
    end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
    import exc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reset_req,
    input logic [31:0] cur_psr,
    input logic [31:0] ret_addr,
    input logic        take_valid,
    input logic [4:0]  take_mode,
    input logic [31:0] take_vector,
    input logic [31:0] take_link,
    input logic [31:0] take_spsr,
    input logic [31:0] take_psr,
    input logic        ret_valid
);
    // R5
    entry_bits_chk: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> (take_psr[PSR_I] && !take_psr[PSR_T] && take_psr[4:0] == take_mode));

    // R5
    fiq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (take_valid && take_mode == MODE_FIQ) |-> take_psr[PSR_F]);

    // R4
    save_copy_chk: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> (take_spsr == $past(cur_psr) && take_link == $past(ret_addr)));

    // R7
    reset_now_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> (take_valid && take_vector == 32'h0));

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (take_valid && take_vector == 32'h18) |-> !$past(cur_psr[PSR_I]));

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take_valid, ret_valid}));

    // R8
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        (!take_valid && !$past(rst)) |-> ($stable(take_vector) && $stable(take_psr)));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reset_req   (reset_req),
    .cur_psr     (cur_psr),
    .ret_addr    (ret_addr),
    .take_valid  (take_valid),
    .take_mode   (take_mode),
    .take_vector (take_vector),
    .take_link   (take_link),
    .take_spsr   (take_spsr),
    .take_psr    (take_psr),
    .ret_valid   (ret_valid)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reset_req = 0, dabort_req = 0, fiq_req = 0, irq_req = 0;
    logic        pabort_req = 0, undef_req = 0, swi_req = 0;
    logic        boundary = 0, ret_req = 0;
    logic [31:0] cur_psr = 0, ret_addr = 0, resume_pc = 0;
    logic        take_valid, ret_valid;
    logic [4:0]  take_mode;
    logic [31:0] take_vector, take_link, take_spsr, take_psr, ret_psr, ret_pc;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    exc_entry_ctrl u_dut (
        .clk(clk), .rst(rst), .reset_req(reset_req), .dabort_req(dabort_req),
        .fiq_req(fiq_req), .irq_req(irq_req), .pabort_req(pabort_req),
        .undef_req(undef_req), .swi_req(swi_req), .boundary(boundary),
        .ret_req(ret_req), .cur_psr(cur_psr), .ret_addr(ret_addr),
        .resume_pc(resume_pc), .take_valid(take_valid), .take_mode(take_mode),
        .take_vector(take_vector), .take_link(take_link), .take_spsr(take_spsr),
        .take_psr(take_psr), .ret_valid(ret_valid), .ret_psr(ret_psr), .ret_pc(ret_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_req(input logic [6:0] r, input logic bnd);
        {swi_req, undef_req, pabort_req, irq_req, fiq_req, dabort_req, reset_req} = r;
        boundary = bnd;
    endtask

    // expected behaviour from the requirements: index 0..6 in R1 order, 7 = none
    function automatic int pick(input logic [6:0] r, input logic bnd, input logic [31:0] psr);
        logic [6:0] e;
        e    = bnd ? r : 7'b0;
        e[0] = r[0];
        if (psr[6]) e[2] = 1'b0;
        if (psr[7]) e[3] = 1'b0;
        for (int i = 0; i < 7; i++) if (e[i]) return i;
        return 7;
    endfunction

    function automatic logic [31:0] vec_of(input int k);
        case (k)
            0: return 32'h00; 1: return 32'h10; 2: return 32'h1C; 3: return 32'h18;
            4: return 32'h0C; 5: return 32'h04; default: return 32'h08;
        endcase
    endfunction

    function automatic logic [4:0] mode_of(input int k);
        case (k)
            0, 6: return 5'b10011; 1, 4: return 5'b10111; 2: return 5'b10001;
            3: return 5'b10010; default: return 5'b11011;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] psr, ra, prev_vec, prev_psr, exp_psr, p_irq, p_fiq;
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        check("R11 take_valid", {31'b0, take_valid}, 32'h0);
        check("R11 ret_valid", {31'b0, ret_valid}, 32'h0);
        check("R11 vector", take_vector, 32'h0);

        // sweep requests x masks x boundary
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 2; b++) begin
                for (int r = 0; r < 128; r++) begin
                    psr = 32'hA000_0030 | (32'(m) << 6);
                    ra  = 32'h1000_0000 + 32'(r * 8 + m * 2 + b);
                    prev_vec = take_vector;
                    prev_psr = take_psr;
                    @(negedge clk);
                    drive_req(7'(r), b[0]);
                    cur_psr  = psr;
                    ret_addr = ra;
                    @(negedge clk);
                    drive_req(7'b0, 1'b0);
                    k = pick(7'(r), b[0], psr);
                    if (k == 7) begin
                        // R6 R7 R8: nothing accepted, outputs held
                        check("R8 no strobe", {31'b0, take_valid}, 32'h0);
                        check("R8 hold vector", take_vector, prev_vec);
                        check("R8 hold psr", take_psr, prev_psr);
                    end else begin
                        exp_psr = psr;
                        exp_psr[4:0] = mode_of(k);
                        exp_psr[5] = 1'b0;
                        exp_psr[7] = 1'b1;
                        if (k == 0 || k == 2) exp_psr[6] = 1'b1;
                        check("R8 strobe", {31'b0, take_valid}, 32'h1);
                        check("R1 R2 vector", take_vector, vec_of(k));
                        check("R3 mode", {27'b0, take_mode}, {27'b0, mode_of(k)});
                        check("R4 spsr", take_spsr, psr);
                        check("R4 link", take_link, ra);
                        check("R5 new psr", take_psr, exp_psr);
                        prev_vec = take_vector;
                        prev_psr = take_psr;
                        @(negedge clk);
                        check("R8 one cycle", {31'b0, take_valid}, 32'h0);
                        check("R8 hold after", take_vector, prev_vec);
                    end
                end
            end
        end

        // R9: enter irq then fiq with distinct status words, return from each
        p_irq = 32'h1234_0010;
        p_fiq = 32'h5678_0090;
        @(negedge clk); cur_psr = p_irq; drive_req(7'b0001000, 1'b1);
        @(negedge clk); cur_psr = p_fiq; drive_req(7'b0000100, 1'b1);
        @(negedge clk); drive_req(7'b0, 1'b0);
        cur_psr = 32'h0000_00D2; ret_req = 1'b1; resume_pc = 32'hCAFE_0004;
        @(negedge clk); ret_req = 1'b0;
        check("R9 ret strobe irq", {31'b0, ret_valid}, 32'h1);
        check("R9 ret psr irq", ret_psr, p_irq);
        check("R9 ret pc irq", ret_pc, 32'hCAFE_0004);
        cur_psr = 32'h0000_00D1; ret_req = 1'b1; resume_pc = 32'hBEEF_0008;
        @(negedge clk); ret_req = 1'b0;
        check("R9 ret psr fiq", ret_psr, p_fiq);
        check("R9 ret pc fiq", ret_pc, 32'hBEEF_0008);
        @(negedge clk);
        check("R9 ret one cycle", {31'b0, ret_valid}, 32'h0);

        // R10: return in user and system mode ignored
        cur_psr = 32'h0000_0010; ret_req = 1'b1; resume_pc = 32'h1111_1111;
        @(negedge clk);
        check("R10 user ret", {31'b0, ret_valid}, 32'h0);
        check("R10 user pc held", ret_pc, 32'hBEEF_0008);
        cur_psr = 32'h0000_001F;
        @(negedge clk); ret_req = 1'b0;
        check("R10 system ret", {31'b0, ret_valid}, 32'h0);

        // R10: return together with an entry, entry wins
        cur_psr = 32'h0000_0012; ret_req = 1'b1; drive_req(7'b0000010, 1'b1);
        resume_pc = 32'h2222_2222;
        @(negedge clk); ret_req = 1'b0; drive_req(7'b0, 1'b0);
        check("R10 entry wins", {31'b0, take_valid}, 32'h1);
        check("R10 no ret", {31'b0, ret_valid}, 32'h0);
        check("R10 ret pc held", ret_pc, 32'hBEEF_0008);

        // R11: block reset mid-run clears outputs
        drive_req(7'b0000001, 1'b0);
        @(negedge clk); drive_req(7'b0, 1'b0); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R11 cleared valid", {31'b0, take_valid}, 32'h0);
        check("R11 cleared psr", take_psr, 32'h0);
        check("R11 cleared ret pc", ret_pc, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule